// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is a small timer peripheral that sits behind a simple synchronous register bus. It holds two counters. The event counter runs on a slow timer clock. It compares its value against a programmed match value and raises an interrupt pulse when the two are equal. It can also return to zero on a match, which gives a periodic tick. The free-running counter runs on the bus clock through a small prescaler. Software reads it as a continuous time base.

Software arms a one-shot event in four steps. It stops the event counter, writes the clear register and the match value, polls the clear-pending status bit until the clear has reached the timer clock domain, and then sets the run bit again. The bus clock is assumed to be at least four times faster than the timer clock. The clear request, the control bits, the interrupt and the count readback each cross between the two clocks through handshakes or synchronisers inside the block.

Register offsets (byte addresses): match 0x00, event count 0x04, control 0x08, clear 0x0C, prescale select 0x10, free-running count 0x14, status 0x18.

Top module: `match_event_timer`

## Requirements
- R1: After reset, every register reads 0 (the free-running count only until its first prescaler tick), the interrupt output is low and the status pending bit is 0.
- R2: The match register (0x00), control register (0x08, bit 0 = run, bit 1 = zero-on-match) and prescale select (0x10, bits [1:0]) read back what was written. Bits above each field's width read 0.
- R3: While control bit 0 is 1, the event count at 0x04 goes up by one per timer clock. While the bit is 0, the count holds. Bus writes to 0x04 and 0x18 change nothing.
- R4: When the run bit is set and the event count equals the match value, match_irq goes high for exactly one bus clock, once for each such timer cycle.
- R5: With control bit 1 clear, the count passes the match value and keeps going. With bit 1 set, the count goes back to 0 on the tick after a match, so events recur every match+1 timer ticks.
- R6: A write to 0x0C, with any data, sets the event count to 0. This holds whether the counter is running or stopped.
- R7: Status bit 10 at 0x18 reads 1 from the bus cycle after a clear write until the clear has taken effect in the timer domain. It then reads 0 again.
- R8: The free-running count at 0x14 starts counting when reset is released. It goes up by one every code+1 bus clocks, where code is the prescale select value 0 to 3 (a code of 3 divides by four).
- R9: Both counters wrap modulo 2^CNT_W.
- R10: While the run bit is 0, no interrupt pulse is produced, even when the count equals the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock, also clocks the free-running counter |
| bus_rst_n | input | 1 | Active-low asynchronous reset for the bus domain |
| tmr_clk | input | 1 | Slow timer clock for the event counter |
| tmr_rst_n | input | 1 | Active-low asynchronous reset for the timer domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| match_irq | output | 1 | One-bus-cycle interrupt pulse on a match |

## Verification
The hardest situations to reach are the counter wrapping in both domains and the window in which a clear is still crossing clocks. The bench builds the block with a 10-bit counter width. This lets an unchanged match value be hit a second time after the event counter wraps, and lets the free-running count come back round within about a thousand bus cycles. The pending window is caught by reading status on the very next bus cycle after a clear write, and then polling until it drops.

// File: rtl/evtmr_pkg.sv
`timescale 1ns/1ps
package evtmr_pkg;
   localparam int OFS_MATCH = 'h00;
   localparam int OFS_COUNT = 'h04;
   localparam int OFS_CTRL  = 'h08;
   localparam int OFS_CLEAR = 'h0C;
   localparam int OFS_DIV   = 'h10;
   localparam int OFS_FREE  = 'h14;
   localparam int OFS_STAT  = 'h18;
   localparam int STAT_PEND_BIT = 10;

   typedef struct packed {
      logic zero_on_match;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/evtmr_sync.sv
`timescale 1ns/1ps
module evtmr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evtmr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/evtmr_clear_xing.sv
`timescale 1ns/1ps
module evtmr_clear_xing #(
   parameter int STAGES = 2
) (
   input  logic bus_clk,
   input  logic bus_rst_n,
   input  logic clr_wr,
   output logic pending,
   input  logic tmr_clk,
   input  logic tmr_rst_n,
   output logic tmr_clr
);
   logic req_q;
   logic req_s;
   logic req_seen;
   logic ack_s;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) req_q <= 1'b0;
      else if (clr_wr) req_q <= ~req_q;
   end

   evtmr_sync #(.WIDTH(1), .STAGES(STAGES)) u_req_sync (
      .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_q), .q(req_s));

   always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
      if (!tmr_rst_n) req_seen <= 1'b0;
      else req_seen <= req_s;
   end

   assign tmr_clr = req_s ^ req_seen;

   evtmr_sync #(.WIDTH(1), .STAGES(STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(req_seen), .q(ack_s));

   assign pending = req_q ^ ack_s;

   // R7: a clear write raises the pending flag on the following cycle
   assert_pend_after_clear_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (clr_wr && !pending) |=> pending);
endmodule

// File: rtl/evtmr_event_ctr.sv
`timescale 1ns/1ps
module evtmr_event_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             zero_on_match,
   input  logic [CNT_W-1:0] match_val,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             hit_tgl,
   output logic             snap_tgl
);
   logic hit;
   assign hit = run && (cnt == match_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         hit_tgl  <= 1'b0;
         snap_tgl <= 1'b0;
      end else begin
         snap_tgl <= ~snap_tgl;
         if (hit) hit_tgl <= ~hit_tgl;
         if (clr) cnt <= '0;
         else if (run) begin
            if (hit && zero_on_match) cnt <= '0;
            else cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // R6: a delivered clear zeroes the count
   assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R3: stopped counter holds its value
   assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !run) |=> $stable(cnt));
   // R9: running counter steps by one, wrapping at the top
   assert_step_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && run && (cnt != match_val)) |=> (cnt == $past(cnt) + CNT_W'(1)));
   // R5: zero-on-match returns to zero after a hit
   assert_zero_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && run && zero_on_match && (cnt == match_val)) |=> (cnt == '0));
endmodule

// File: rtl/evtmr_free_ctr.sv
`timescale 1ns/1ps
module evtmr_free_ctr #(
   parameter int CNT_W = 32,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_code,
   output logic [CNT_W-1:0] cnt
);
   logic [DIV_W-1:0] pre;
   logic             tick;

   assign tick = (pre >= div_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
         cnt <= '0;
      end else if (tick) begin
         pre <= '0;
         cnt <= cnt + CNT_W'(1);
      end else begin
         pre <= pre + DIV_W'(1);
      end
   end

   // R8: the count only moves on a prescaler tick
   assert_free_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   // R9: a tick steps by one modulo 2^CNT_W
   assert_free_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/match_event_timer.sv
`timescale 1ns/1ps
module match_event_timer
   import evtmr_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int CNT_W       = 32,
   parameter int DIV_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              tmr_clk,
   input  logic              tmr_rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              match_irq
);
   localparam int CTRL_W = $bits(ctrl_t);

   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("match_event_timer: CNT_W exceeds DATA_W");
      end
      if (DATA_W <= STAT_PEND_BIT) begin : g_bad_data
         $error("match_event_timer: DATA_W too narrow for status");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("match_event_timer: ADDR_W too narrow for the map");
      end
   endgenerate

   // ---------------- bus-side registers ----------------
   logic [CNT_W-1:0] match_q;
   ctrl_t            ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic             wr_match, wr_ctrl, wr_clear, wr_div;

   assign wr_match = bus_wr && (bus_addr == ADDR_W'(OFS_MATCH));
   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_clear = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
   assign wr_div   = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         match_q <= '0;
         ctrl_q  <= '0;
         div_q   <= '0;
      end else begin
         if (wr_match) match_q <= bus_wdata[CNT_W-1:0];
         if (wr_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_div)   div_q   <= bus_wdata[DIV_W-1:0];
      end
   end

   // ---------------- clear crossing ----------------
   logic pending;
   logic tmr_clr;

   evtmr_clear_xing #(.STAGES(SYNC_STAGES)) u_clear (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .clr_wr(wr_clear), .pending(pending),
      .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .tmr_clr(tmr_clr));

   // ---------------- timer domain ----------------
   ctrl_t            tmr_ctrl;
   logic [CNT_W-1:0] tmr_cnt;
   logic             hit_tgl;
   logic             snap_tgl;

   evtmr_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
      .clk(tmr_clk), .rst_n(tmr_rst_n), .d(ctrl_q), .q(tmr_ctrl));

   evtmr_event_ctr #(.CNT_W(CNT_W)) u_event (
      .clk(tmr_clk), .rst_n(tmr_rst_n), .run(tmr_ctrl.run),
      .zero_on_match(tmr_ctrl.zero_on_match), .match_val(match_q),
      .clr(tmr_clr), .cnt(tmr_cnt), .hit_tgl(hit_tgl), .snap_tgl(snap_tgl));

   // ---------------- back into the bus domain ----------------
   logic             hit_s, hit_seen, irq_q;
   logic             snap_s, snap_seen;
   logic [CNT_W-1:0] cnt_rd;

   evtmr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_back_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d({hit_tgl, snap_tgl}), .q({hit_s, snap_s}));

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         hit_seen  <= 1'b0;
         irq_q     <= 1'b0;
         snap_seen <= 1'b0;
         cnt_rd    <= '0;
      end else begin
         hit_seen  <= hit_s;
         irq_q     <= hit_s ^ hit_seen;
         snap_seen <= snap_s;
         if (snap_s ^ snap_seen) cnt_rd <= tmr_cnt;
      end
   end

   assign match_irq = irq_q;

   // ---------------- free-running time base ----------------
   logic [CNT_W-1:0] free_cnt;

   evtmr_free_ctr #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_free (
      .clk(bus_clk), .rst_n(bus_rst_n), .div_code(div_q), .cnt(free_cnt));

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_MATCH): bus_rdata = DATA_W'(match_q);
         ADDR_W'(OFS_COUNT): bus_rdata = DATA_W'(cnt_rd);
         ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl_q);
         ADDR_W'(OFS_DIV):   bus_rdata = DATA_W'(div_q);
         ADDR_W'(OFS_FREE):  bus_rdata = DATA_W'(free_cnt);
         ADDR_W'(OFS_STAT):  bus_rdata[STAT_PEND_BIT] = pending;
         default:            bus_rdata = '0;
      endcase
   end

   // R4: the interrupt is a single bus-cycle pulse
   assert_irq_single_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      match_irq |=> !match_irq);
   // R3: the count readback changes only when a fresh sample arrives
   assert_readback_coherent_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !(snap_s ^ snap_seen) |=> $stable(cnt_rd));
   // R2: a match write lands in the register
   assert_match_write_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      wr_match |=> (match_q == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: tb/match_event_timer_test.sv
`timescale 1ns/1ps
module match_event_timer_test;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam int CW = 10;

   logic          bus_clk = 1'b0;
   logic          tmr_clk = 1'b0;
   logic          bus_rst_n = 1'b0;
   logic          tmr_rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          match_irq;

   int total = 0;
   int bad = 0;
   int irq_cnt = 0;
   bit finished = 0;

   always #5 bus_clk = ~bus_clk;
   always #40 tmr_clk = ~tmr_clk;

   match_event_timer #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) uut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .match_irq(match_irq));

   always @(negedge bus_clk) if (match_irq) irq_cnt <= irq_cnt + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge bus_clk);
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge bus_clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      @(negedge bus_clk);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   task automatic tmr_wait(input int n);
      repeat (n) @(posedge tmr_clk);
   endtask

   // stop, clear and wait for the clear to land
   task automatic stop_and_clear();
      logic [DW-1:0] s;
      wr('h08, 0);
      tmr_wait(4);
      wr('h0C, 32'h1234);
      for (int i = 0; i < 60; i++) begin
         rd('h18, s);
         if (!s[10]) break;
      end
      tmr_wait(4);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      rd('h00, d); check(d == 0, "R1 match reset", d, 0);
      rd('h04, d); check(d == 0, "R1 count reset", d, 0);
      rd('h08, d); check(d == 0, "R1 ctrl reset", d, 0);
      rd('h18, d); check(d == 0, "R1 status reset", d, 0);
      check(match_irq == 0, "R1 irq reset", match_irq, 0);
   endtask

   task automatic t_readback();
      logic [DW-1:0] d;
      wr('h00, 32'hFFFF_FFFF); rd('h00, d); check(d == 32'h3FF, "R2 match readback", d, 32'h3FF);
      wr('h08, 32'hFFFF_FFF0); rd('h08, d); check(d == 0, "R2 ctrl upper bits", d, 0);
      wr('h08, 32'h2);         rd('h08, d); check(d == 2, "R2 ctrl readback", d, 2);
      wr('h10, 32'hFF);        rd('h10, d); check(d == 3, "R2 div readback", d, 3);
      wr('h08, 0);
      wr('h00, 32'h3FF);
   endtask

   task automatic t_count_run_hold();
      logic [DW-1:0] a, b;
      stop_and_clear();
      wr('h08, 1);
      tmr_wait(20);
      wr('h08, 0);
      tmr_wait(6);
      rd('h04, a);
      check(a >= 18 && a <= 22, "R3 count advances", a, 20);
      tmr_wait(10);
      rd('h04, b);
      check(b == a, "R3 count holds when stopped", b, a);
      wr('h04, 32'h155); wr('h18, 32'hFFFF_FFFF);
      tmr_wait(6);
      rd('h04, b); check(b == a, "R3 write to count ignored", b, a);
      rd('h18, b); check(b == 0, "R3 write to status ignored", b, 0);
   endtask

   task automatic t_clear_pending();
      logic [DW-1:0] s, c;
      int polls;
      bit seen_low;
      wr('h0C, 0);
      rd('h18, s);
      check(s[10] == 1'b1, "R7 pending right after clear", s[10], 1);
      seen_low = 0; polls = 0;
      for (int i = 0; i < 60; i++) begin
         rd('h18, s); polls++;
         if (!s[10]) begin seen_low = 1; break; end
      end
      check(seen_low, "R7 pending drops", polls, 60);
      tmr_wait(4);
      rd('h04, c);
      check(c == 0, "R6 clear with zero data", c, 0);
   endtask

   task automatic t_clear_running();
      logic [DW-1:0] c;
      stop_and_clear();
      wr('h00, 32'h3FF);
      wr('h08, 1);
      tmr_wait(40);
      wr('h0C, 32'hDEAD);
      tmr_wait(6);
      wr('h08, 0);
      tmr_wait(6);
      rd('h04, c);
      check(c <= 12, "R6 clear while running", c, 6);
   endtask

   task automatic t_match_oneshot();
      logic [DW-1:0] c;
      int base;
      stop_and_clear();
      wr('h00, 10);
      base = irq_cnt;
      wr('h08, 1);
      tmr_wait(30);
      wr('h08, 0);
      tmr_wait(6);
      check(irq_cnt - base == 1, "R4 one pulse on match", irq_cnt - base, 1);
      rd('h04, c);
      check(c > 10, "R5 count passes match", c, 30);
   endtask

   task automatic t_match_periodic();
      logic [DW-1:0] c;
      int base;
      stop_and_clear();
      wr('h00, 5);
      base = irq_cnt;
      wr('h08, 3);
      tmr_wait(60);
      wr('h08, 0);
      tmr_wait(6);
      check(irq_cnt - base >= 9 && irq_cnt - base <= 11, "R5 periodic pulses", irq_cnt - base, 10);
      rd('h04, c);
      check(c <= 5, "R5 count bounded by match", c, 5);
   endtask

   task automatic t_disabled();
      int base;
      stop_and_clear();
      wr('h00, 0);
      base = irq_cnt;
      tmr_wait(30);
      check(irq_cnt == base, "R10 no irq when stopped", irq_cnt - base, 0);
   endtask

   task automatic t_event_wrap();
      int base;
      stop_and_clear();
      wr('h00, 2);
      base = irq_cnt;
      wr('h08, 1);
      tmr_wait(1040);
      wr('h08, 0);
      tmr_wait(6);
      check(irq_cnt - base == 2, "R9 event count wraps and re-matches", irq_cnt - base, 2);
   endtask

   task automatic t_divider(input int code, input int win, input int exp);
      logic [DW-1:0] a, b;
      longint diff;
      wr('h10, code);
      repeat (8) @(negedge bus_clk);
      rd('h14, a);
      repeat (win - 1) @(negedge bus_clk);
      rd('h14, b);
      diff = (longint'(b) - longint'(a) + 1024) % 1024;
      check(diff == exp, $sformatf("R8 prescale code %0d", code), diff, exp);
   endtask

   task automatic t_free_wrap();
      logic [DW-1:0] a, b;
      longint expv;
      wr('h10, 0);
      repeat (4) @(negedge bus_clk);
      rd('h14, a);
      repeat (1029) @(negedge bus_clk);
      rd('h14, b);
      expv = (longint'(a) + 1030) % 1024;
      check(b == expv, "R9 free count wraps", b, expv);
   endtask

   initial begin
      repeat (3) @(negedge bus_clk);
      #3;
      tmr_rst_n = 1'b1;
      bus_rst_n = 1'b1;
      t_reset();
      t_readback();
      t_count_run_hold();
      t_clear_pending();
      t_clear_running();
      t_match_oneshot();
      t_match_periodic();
      t_disabled();
      t_event_wrap();
      t_divider(3, 60, 15);
      t_divider(0, 60, 60);
      t_divider(1, 60, 30);
      t_divider(2, 60, 20);
      t_free_wrap();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule